// File: doc/BRIEF.md
# Configuration Word Store Command Controller

This block gives a host a two-register window onto a small store of 16-bit configuration words. The host writes a command word holding an operation code and a word address. The block then runs a read, a program, an erase or a program-unlock against its internal word array. While an operation runs it raises a busy flag, which the host polls in bit 15 of the command register. Operand data for a program is placed in the data register beforehand. When a read finishes, the word it fetched is in the same data register.

Programming and erasing are locked after reset. They take effect only once the unlock command has been accepted. The array is modelled with flops and reloads its factory image on reset. The image has a manufacturer word at index 7, a product word at index 3 and zero elsewhere. Serial pin signalling and retention across power loss are outside this model.

The sequencer has three states. ST_IDLE waits for a command. ST_READ counts down the read latency. ST_PROG counts down the program or erase latency. The transitions are:
- idle-to-read on an accepted read.
- idle-to-prog on an accepted program or erase while unlocked.
- read-to-idle and prog-to-idle when the countdown reaches zero.

Every other case stays in its state. This includes unlock, no-op and locked program or erase commands, which all remain in ST_IDLE.

Top module: `nvcfg_ctrl`

## Requirements
- R1: After reset the busy flag is 0 and the test flag is 0. The data register reads 0x0000, programming is locked, and the array holds MFG_WORD (default 0x6D50) at index 7, PROD_WORD (default 0x9150) at index 3 and 0x0000 at every other index.
- R2: The command word is decoded as follows. Bits [5:0] are the word address. Bits [7:6] select the operation: 2'b10 is read, 2'b01 is program and 2'b11 is erase. With bits [7:6] at 2'b00, bits [5:4] equal to 2'b11 mean unlock, and any other value is a no-op that leaves the array unchanged.
- R3: An accepted read holds busy high for exactly READ_CYCLES clock cycles, starting at the accepting edge. At the edge where busy falls, the data register takes the addressed word.
- R4: An accepted program while unlocked holds busy high for exactly PROG_CYCLES cycles and then stores the data register value at the addressed word.
- R5: An accepted erase while unlocked holds busy high for exactly PROG_CYCLES cycles and then sets the addressed word to 0xFFFF.
- R6: While programming is locked, program and erase commands do not raise busy and do not change the array.
- R7: A command written while busy is high is ignored. It changes neither the running operation's address or timing, nor the array, nor the command readback.
- R8: A data register write is taken when busy is low. It is ignored while busy is high.
- R9: The command register reads back as follows. Bit 15 is busy. Bit 14 is the test flag, taken from bit 14 of the last accepted command. Bits [13:8] are 0. Bits [7:0] are the low byte of the last accepted command.
- R10: The unlock command (0x0030) takes effect at its accepting edge and does not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 16 | Command word |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 16 | Data register write value |
| cmd_rdata | output | 16 | Command/status readback |
| dat_rdata | output | 16 | Data register readback |

## Verification
The assertions watch several properties on every cycle:
- A locked program or erase never leaves ST_IDLE.
- A countdown at zero always drops busy on the next edge.
- The latched address holds steady through a busy period.
- The data register does not move while busy except at read completion.
- An erase leaves 0xFFFF in the addressed word.
- Unlock never raises busy.

Exact busy lengths, the decoded effect of each opcode on array contents, the factory image after reset, and the readback of the test flag and last command byte can only be shown by the bench's command sequences and read-backs.

// File: rtl/nvcfg_pkg.sv
package nvcfg_pkg;
    localparam int WORD_W = 16;

    localparam logic [1:0] OPC_MISC  = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;
    localparam logic [1:0] SUB_UNLOCK = 2'b11;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE,
        OP_ERASE,
        OP_UNLOCK
    } nv_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_PROG
    } nv_state_e;
endpackage

// File: rtl/nvcfg_decode.sv
module nvcfg_decode
    import nvcfg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [7:0]        cmd_lo,
    output nv_op_e            op,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        addr = cmd_lo[ADDR_W-1:0];
        unique case (cmd_lo[7:6])
            OPC_READ:  op = OP_READ;
            OPC_WRITE: op = OP_WRITE;
            OPC_ERASE: op = OP_ERASE;
            OPC_MISC:  op = (cmd_lo[5:4] == SUB_UNLOCK) ? OP_UNLOCK : OP_NONE;
            default:   op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/nvcfg_seq.sv
module nvcfg_seq
    import nvcfg_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int READ_CYCLES = 4,
    parameter int PROG_CYCLES = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  nv_op_e            op,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              busy,
    output logic              accept,
    output logic              wr_en,
    output logic              rd_fire,
    output logic              pg_fire,
    output logic              pg_erase,
    output logic [ADDR_W-1:0] addr_q
);
    localparam int MAX_CYC = (PROG_CYCLES > READ_CYCLES) ? PROG_CYCLES : READ_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(READ_CYCLES - 1);
    localparam logic [CNT_W-1:0] PG_LOAD = CNT_W'(PROG_CYCLES - 1);

    nv_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [ADDR_W-1:0] addr_d;
    logic              erase_q, erase_d;
    logic              unlk_q, unlk_d;

    // next-state and datapath selection
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        addr_d  = addr_q;
        erase_d = erase_q;
        unlk_d  = unlk_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_we) begin
                    unique case (op)
                        OP_READ: begin
                            state_d = ST_READ;
                            cnt_d   = RD_LOAD;
                            addr_d  = addr_in;
                        end
                        OP_WRITE, OP_ERASE: begin
                            if (unlk_q) begin
                                state_d = ST_PROG;
                                cnt_d   = PG_LOAD;
                                addr_d  = addr_in;
                                erase_d = (op == OP_ERASE);
                            end
                        end
                        OP_UNLOCK: unlk_d = 1'b1;
                        default: ;
                    endcase
                end
            end
            ST_READ, ST_PROG: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            erase_q <= 1'b0;
            unlk_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            addr_q  <= addr_d;
            erase_q <= erase_d;
            unlk_q  <= unlk_d;
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        accept   = cmd_we && (state_q == ST_IDLE);
        wr_en    = unlk_q;
        rd_fire  = (state_q == ST_READ) && (cnt_q == '0);
        pg_fire  = (state_q == ST_PROG) && (cnt_q == '0);
        pg_erase = erase_q;
    end

    assert_refuse_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cmd_we && (op == OP_WRITE || op == OP_ERASE) && !unlk_q)
        |=> (state_q == ST_IDLE));

    assert_busy_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && cnt_q == '0) |=> (state_q == ST_IDLE));

    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && cnt_q != '0) |=> $stable(addr_q));
endmodule

// File: rtl/nvcfg_array.sv
module nvcfg_array
    import nvcfg_pkg::*;
#(
    parameter int          ADDR_W    = 6,
    parameter logic [15:0] MFG_WORD  = 16'h6D50,
    parameter logic [15:0] PROD_WORD = 16'h9150
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    function automatic logic [WORD_W-1:0] image_word(input int idx);
        if (idx == 7)      return MFG_WORD;
        else if (idx == 3) return PROD_WORD;
        else               return '0;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= image_word(i);
        end else if (we) begin
            mem[addr] <= erase ? {WORD_W{1'b1}} : wdata;
        end
    end

    assign rdata = mem[addr];

    assert_erase_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && erase) |=> (mem[$past(addr)] == {WORD_W{1'b1}}));
endmodule

// File: rtl/nvcfg_ctrl.sv
module nvcfg_ctrl
    import nvcfg_pkg::*;
#(
    parameter int          ADDR_W      = 6,
    parameter int          READ_CYCLES = 4,
    parameter int          PROG_CYCLES = 12,
    parameter logic [15:0] MFG_WORD    = 16'h6D50,
    parameter logic [15:0] PROD_WORD   = 16'h9150
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic [15:0] cmd_wdata,
    input  logic        dat_we,
    input  logic [15:0] dat_wdata,
    output logic [15:0] cmd_rdata,
    output logic [15:0] dat_rdata
);
    nv_op_e            op;
    logic [ADDR_W-1:0] dec_addr, addr_q;
    logic              busy, accept, wr_en, rd_fire, pg_fire, pg_erase;
    logic [15:0]       arr_rdata;
    logic [15:0]       dreg_q;
    logic [7:0]        last_q;
    logic              test_q;
    logic              unused_cmd_bits;

    assign unused_cmd_bits = ^{cmd_wdata[15], cmd_wdata[13:8]};

    nvcfg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .cmd_lo (cmd_wdata[7:0]),
        .op     (op),
        .addr   (dec_addr)
    );

    nvcfg_seq #(
        .ADDR_W      (ADDR_W),
        .READ_CYCLES (READ_CYCLES),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (cmd_we),
        .op       (op),
        .addr_in  (dec_addr),
        .busy     (busy),
        .accept   (accept),
        .wr_en    (wr_en),
        .rd_fire  (rd_fire),
        .pg_fire  (pg_fire),
        .pg_erase (pg_erase),
        .addr_q   (addr_q)
    );

    nvcfg_array #(
        .ADDR_W    (ADDR_W),
        .MFG_WORD  (MFG_WORD),
        .PROD_WORD (PROD_WORD)
    ) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pg_fire),
        .erase (pg_erase),
        .addr  (addr_q),
        .wdata (dreg_q),
        .rdata (arr_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dreg_q <= '0;
            last_q <= '0;
            test_q <= 1'b0;
        end else begin
            if (accept) begin
                last_q <= cmd_wdata[7:0];
                test_q <= cmd_wdata[14];
            end
            if (rd_fire)               dreg_q <= arr_rdata;
            else if (dat_we && !busy)  dreg_q <= dat_wdata;
        end
    end

    assign cmd_rdata = {busy, test_q, 6'b000000, last_q};
    assign dat_rdata = dreg_q;

    assert_dreg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_fire) |=> $stable(dreg_q));

    assert_unlock_nobusy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_UNLOCK) |=> (!busy && wr_en));
endmodule

// File: tb/sim_nvcfg_ctrl.sv
module sim_nvcfg_ctrl;
    localparam int RDC = 4;
    localparam int PGC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic        dat_we = 1'b0;
    logic [15:0] dat_wdata = '0;
    logic [15:0] cmd_rdata, dat_rdata;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    nvcfg_ctrl #(.READ_CYCLES(RDC), .PROG_CYCLES(PGC)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata),
        .cmd_rdata(cmd_rdata), .dat_rdata(dat_rdata)
    );

    // {busy_len[4:0], chk, data, command, expected}
    localparam int NV = 14;
    localparam logic [53:0] VEC [NV] = '{
        {5'd0,      1'b0, 16'h1234, 16'h0045, 16'h0000}, // R6 locked program
        {5'(RDC),   1'b1, 16'hDEAD, 16'h0085, 16'h0000}, // R6 word 5 untouched
        {5'd0,      1'b0, 16'h1234, 16'h00C7, 16'h0000}, // R6 locked erase
        {5'(RDC),   1'b1, 16'hDEAD, 16'h0087, 16'h6D50}, // R6 word 7 untouched
        {5'd0,      1'b0, 16'h0000, 16'h0030, 16'h0000}, // R10 unlock
        {5'(PGC),   1'b0, 16'hA5A5, 16'h0045, 16'h0000}, // R4 program
        {5'(RDC),   1'b1, 16'hDEAD, 16'h0085, 16'hA5A5}, // R3 R4
        {5'(PGC),   1'b0, 16'h0F0F, 16'h007F, 16'h0000}, // R4 top address
        {5'(RDC),   1'b1, 16'hDEAD, 16'h00BF, 16'h0F0F}, // R2 address 63
        {5'(PGC),   1'b0, 16'h0000, 16'h00C5, 16'h0000}, // R5 erase
        {5'(RDC),   1'b1, 16'hDEAD, 16'h0085, 16'hFFFF}, // R5
        {5'd0,      1'b0, 16'h0000, 16'h0025, 16'h0000}, // R2 no-op
        {5'(RDC),   1'b1, 16'hDEAD, 16'h0083, 16'h9150}, // R1 product word
        {5'(RDC),   1'b1, 16'hDEAD, 16'h00BF, 16'h0F0F}  // R2 no-op left array
    };

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_dat(input logic [15:0] v);
        @(negedge clk);
        dat_we = 1'b1; dat_wdata = v;
        @(negedge clk);
        dat_we = 1'b0;
    endtask

    task automatic issue(input logic [15:0] c, output int n);
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = c;
        @(negedge clk);
        cmd_we = 1'b0;
        n = 0;
        while (cmd_rdata[15] && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        do_reset();
        // R1 reset state
        check(cmd_rdata == 16'h0000, "R1 status after reset", cmd_rdata, 16'h0000);
        check(dat_rdata == 16'h0000, "R1 data after reset", dat_rdata, 16'h0000);
        issue(16'h0087, n);
        check(dat_rdata == 16'h6D50, "R1 manufacturer word", dat_rdata, 16'h6D50);
        // R8 idle data write
        load_dat(16'h5A5A);
        check(dat_rdata == 16'h5A5A, "R8 idle data write", dat_rdata, 16'h5A5A);

        for (int i = 0; i < NV; i++) begin
            logic [53:0] v;
            v = VEC[i];
            load_dat(v[47:32]);
            issue(v[31:16], n);
            check(n == int'(v[53:49]), $sformatf("R3/R4/R5/R6 busy length vec %0d", i),
                  16'(n), 16'(v[53:49]));
            check(cmd_rdata[7:0] == v[23:16], $sformatf("R9 low byte vec %0d", i),
                  {8'h00, cmd_rdata[7:0]}, {8'h00, v[23:16]});
            if (v[48])
                check(dat_rdata == v[15:0], $sformatf("R3 read data vec %0d", i), dat_rdata, v[15:0]);
        end

        // R9 test flag and reserved bits
        issue(16'h4000, n);
        check(cmd_rdata == 16'h4000, "R9 test flag set", cmd_rdata, 16'h4000);
        issue(16'h0087, n);
        check(cmd_rdata[14] == 1'b0, "R9 test flag cleared", {15'h0, cmd_rdata[14]}, 16'h0000);

        // R7 command while busy ignored
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = 16'h0083;
        @(negedge clk);
        n = 0;
        if (cmd_rdata[15]) n++;
        check(cmd_rdata[15] == 1'b1, "R9 busy bit during read", cmd_rdata, 16'h8083);
        cmd_wdata = 16'h0049;
        dat_we = 1'b1; dat_wdata = 16'h7777;
        @(negedge clk);
        cmd_we = 1'b0; dat_we = 1'b0;
        while (cmd_rdata[15] && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check(n == RDC, "R7 busy length unchanged", 16'(n), 16'(RDC));
        check(dat_rdata == 16'h9150, "R7 running read address kept", dat_rdata, 16'h9150);
        check(cmd_rdata[7:0] == 8'h83, "R7 readback not overwritten", cmd_rdata, 16'h0083);
        issue(16'h0089, n);
        check(dat_rdata == 16'h0000, "R7 ignored program left word 9", dat_rdata, 16'h0000);

        // R8 data write during program ignored
        load_dat(16'h1111);
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = 16'h004A;
        @(negedge clk);
        cmd_we = 1'b0;
        dat_we = 1'b1; dat_wdata = 16'h2222;
        @(negedge clk);
        dat_we = 1'b0;
        check(dat_rdata == 16'h1111, "R8 data write while busy", dat_rdata, 16'h1111);
        n = 0;
        while (cmd_rdata[15] && n < 1000) begin
            n++;
            @(negedge clk);
        end
        issue(16'h008A, n);
        check(dat_rdata == 16'h1111, "R8 programmed value", dat_rdata, 16'h1111);

        // R1 R6 reset relocks and reloads image
        do_reset();
        check(cmd_rdata == 16'h0000, "R1 status after second reset", cmd_rdata, 16'h0000);
        load_dat(16'h3333);
        issue(16'h0045, n);
        check(n == 0, "R6 locked again after reset", 16'(n), 16'h0000);
        issue(16'h0085, n);
        check(dat_rdata == 16'h0000, "R1 image reloaded word 5", dat_rdata, 16'h0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule